// File: doc/BRIEF.md
# Address-Space-Tagged Page Walk Pointer Cache

This block holds table base addresses that a page table walker found at upper levels of the hierarchy. When a translation misses in the translation buffer, the walker presents the virtual page index bits and the requesting address space identifier. The block answers one cycle later with the deepest cached level that matches and the physical base of the next table. The walker then resumes at that point and skips the memory reads for every level above it. If the deepest cached level matches, only the leaf read is left.

The block stores pointers only, never final translations. Each level has its own small set of entries. A level-k entry is keyed by the identifier and by the top k index fields of the virtual address, so walks to nearby addresses share upper entries and hit. Each stored pointer belongs to one address space, and a lookup from another address space never sees it. This closes the timing channel that a shared cache would open between processes. The walker writes an entry on the fill port each time it reads an intermediate table entry. Software-driven invalidation can clear every entry, or only the entries of one address space, in a single cycle.

Top module: `walk_ptr_cache`

## Requirements
- R1: Following reset, every lookup misses: `rsp_hit` is 0, `rsp_level` is 0 and `rsp_base` is 0.
- R2: `rsp_valid` is high exactly one cycle after `lk_valid`. The answer reflects the contents before any fill accepted in the same cycle as the lookup.
- R3: An entry can only hit when its stored address space identifier equals `lk_asid`.
- R4: `lk_vpn` holds LEVELS index fields of IDX_W bits each, and field 1 is the most significant. A level-k entry matches when fields 1 to k are equal. The lower fields are ignored.
- R5: When several levels match, the response gives the deepest one as `rsp_level` (a value from 1 to LEVELS) together with that entry's stored base. A miss returns level 0 and base 0.
- R6: Each level has ENTRIES slots, and a per-level pointer fills them in round-robin order. A fill at one level never removes an entry at another level.
- R7: `inv_asid_en` clears every entry tagged with `inv_asid` by the next cycle. Entries of other identifiers stay.
- R8: `inv_all` clears every entry by the next cycle.
- R9: A fill presented in the same cycle as either invalidate is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Requesting address space identifier |
| lk_vpn | input | LEVELS*IDX_W | Upper virtual index fields, field 1 in the most significant bits |
| rsp_valid | output | 1 | Lookup response strobe, one cycle after request |
| rsp_hit | output | 1 | Some level matched |
| rsp_level | output | $clog2(LEVELS+1) | Deepest matched level, 0 on miss |
| rsp_base | output | BASE_W | Next-table base for the matched level, 0 on miss |
| fill_valid | input | 1 | Write a pointer entry |
| fill_level | input | $clog2(LEVELS+1) | Level of the entry, from 1 to LEVELS |
| fill_asid | input | ASID_W | Owner identifier of the entry |
| fill_vpn | input | LEVELS*IDX_W | Virtual index fields. Only the top fill_level fields are kept |
| fill_base | input | BASE_W | Table base address to store |
| inv_all | input | 1 | Clear all entries |
| inv_asid_en | input | 1 | Clear entries of one identifier |
| inv_asid | input | ASID_W | Identifier to clear |

## Verification
The assertions assume that the walker never fills an entry whose level, identifier and prefix already belong to a valid entry, and that `fill_level` always lies between 1 and LEVELS. Under these conditions at most one entry per level can match, and the hit base can be taken as an OR of the matching entries. The bench keeps a model of the valid contents and only issues fills with keys that are fresh at their level, always with a legal level. Its one-cycle sampling leaves the walker's side free of overlapping requests.

// File: rtl/walk_cache_pkg.sv
package walk_cache_pkg;
  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ASID = 2'd1,
    INV_ALL  = 2'd2
  } inv_op_e;
endpackage

// File: rtl/walk_cache_level.sv
module walk_cache_level
  import walk_cache_pkg::*;
#(
  parameter int LVL     = 1,
  parameter int NFIELD  = 3,
  parameter int IDX_W   = 9,
  parameter int ENTRIES = 4,
  parameter int ASID_W  = 16,
  parameter int BASE_W  = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  inv_op_e                 inv_op,
  input  logic [ASID_W-1:0]       inv_asid,
  input  logic                    fill_en,
  input  logic [ASID_W-1:0]       fill_asid,
  input  logic [NFIELD*IDX_W-1:0] fill_vpn,
  input  logic [BASE_W-1:0]       fill_base,
  input  logic [ASID_W-1:0]       lk_asid,
  input  logic [NFIELD*IDX_W-1:0] lk_vpn,
  output logic                    hit,
  output logic [BASE_W-1:0]       hit_base
);
  localparam int VA_W  = NFIELD * IDX_W;
  localparam int KEEP  = LVL * IDX_W;
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [VA_W-1:0]  MASK = ~({VA_W{1'b1}} >> KEEP);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] v_q;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VA_W-1:0]    tag_q  [ENTRIES];
  logic [BASE_W-1:0]  base_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;
  logic [ENTRIES-1:0] match;

  // valid bits and replacement pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= '0;
      rr_q <= '0;
    end else if (inv_op == INV_ALL) begin
      v_q <= '0;
    end else if (inv_op == INV_ASID) begin
      for (int e = 0; e < ENTRIES; e++)
        if (asid_q[e] == inv_asid) v_q[e] <= 1'b0;
    end else if (fill_en) begin
      v_q[rr_q] <= 1'b1;
      rr_q      <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  // payload storage, write-only port with no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      asid_q[rr_q] <= fill_asid;
      tag_q[rr_q]  <= fill_vpn & MASK;
      base_q[rr_q] <= fill_base;
    end
  end

  always_comb begin
    match    = '0;
    hit_base = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (v_q[e] && asid_q[e] == lk_asid && tag_q[e] == (lk_vpn & MASK)) begin
        match[e] = 1'b1;
        hit_base = hit_base | base_q[e];
      end
    end
  end
  assign hit = |match;

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R6
  fill_count_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> $countones(v_q) == $countones($past(v_q)) + ($past(v_q[rr_q]) ? 0 : 1));

  // R8
  inv_all_chk: assert property (@(posedge clk) disable iff (rst)
    inv_op == INV_ALL |=> v_q == '0);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_inv_chk
    // R7
    inv_asid_clear_chk: assert property (@(posedge clk) disable iff (rst)
      inv_op == INV_ASID |=> !(v_q[e] && asid_q[e] == $past(inv_asid)));
  end
endmodule

// File: rtl/walk_cache_deepest.sv
module walk_cache_deepest #(
  parameter int LEVELS = 3,
  parameter int BASE_W = 40,
  parameter int LVL_W  = 2
) (
  input  logic [LEVELS-1:0]             hit,
  input  logic [LEVELS-1:0][BASE_W-1:0] bases,
  output logic                          any,
  output logic [LVL_W-1:0]              lvl,
  output logic [BASE_W-1:0]             base
);
  always_comb begin
    any  = 1'b0;
    lvl  = '0;
    base = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (hit[k]) begin
        any  = 1'b1;
        lvl  = LVL_W'(k + 1);
        base = bases[k];
      end
    end
  end
endmodule

// File: rtl/walk_ptr_cache.sv
module walk_ptr_cache
  import walk_cache_pkg::*;
#(
  parameter int LEVELS  = 3,
  parameter int IDX_W   = 9,
  parameter int ENTRIES = 4,
  parameter int ASID_W  = 16,
  parameter int BASE_W  = 40,
  localparam int VA_W   = LEVELS * IDX_W,
  localparam int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LVL_W-1:0]  rsp_level,
  output logic [BASE_W-1:0] rsp_base,
  input  logic              fill_valid,
  input  logic [LVL_W-1:0]  fill_level,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VA_W-1:0]   fill_vpn,
  input  logic [BASE_W-1:0] fill_base,
  input  logic              inv_all,
  input  logic              inv_asid_en,
  input  logic [ASID_W-1:0] inv_asid
);
  inv_op_e                       inv_op;
  logic                          fill_go;
  logic [LEVELS-1:0]             lvl_hit;
  logic [LEVELS-1:0][BASE_W-1:0] lvl_base;
  logic                          any_hit;
  logic [LVL_W-1:0]              deep_lvl;
  logic [BASE_W-1:0]             deep_base;

  assign inv_op  = inv_all ? INV_ALL : (inv_asid_en ? INV_ASID : INV_NONE);
  assign fill_go = fill_valid && !inv_all && !inv_asid_en;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    walk_cache_level #(
      .LVL(g + 1), .NFIELD(LEVELS), .IDX_W(IDX_W),
      .ENTRIES(ENTRIES), .ASID_W(ASID_W), .BASE_W(BASE_W)
    ) u_lvl (
      .clk       (clk),
      .rst       (rst),
      .inv_op    (inv_op),
      .inv_asid  (inv_asid),
      .fill_en   (fill_go && fill_level == LVL_W'(g + 1)),
      .fill_asid (fill_asid),
      .fill_vpn  (fill_vpn),
      .fill_base (fill_base),
      .lk_asid   (lk_asid),
      .lk_vpn    (lk_vpn),
      .hit       (lvl_hit[g]),
      .hit_base  (lvl_base[g])
    );
  end

  walk_cache_deepest #(.LEVELS(LEVELS), .BASE_W(BASE_W), .LVL_W(LVL_W)) u_deep (
    .hit   (lvl_hit),
    .bases (lvl_base),
    .any   (any_hit),
    .lvl   (deep_lvl),
    .base  (deep_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_level <= '0;
      rsp_base  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit;
      rsp_level <= (lk_valid && any_hit) ? deep_lvl : '0;
      rsp_base  <= (lk_valid && any_hit) ? deep_base : '0;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R2
  no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid && !rsp_hit);

  // R5
  level_code_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit == (rsp_level != '0));

  // R6
  fill_level_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> fill_level != '0 && int'(fill_level) <= LEVELS);
endmodule

// File: tb/tb_walk_ptr_cache.sv
module tb_walk_ptr_cache;
  localparam int L  = 3;
  localparam int IW = 2;
  localparam int E  = 2;
  localparam int AW = 2;
  localparam int BW = 8;
  localparam int VW = L * IW;
  localparam int LW = $clog2(L + 1);

  logic clk = 0;
  logic rst = 1;
  logic lk_valid = 0, fill_valid = 0, inv_all = 0, inv_asid_en = 0;
  logic [AW-1:0] lk_asid = '0, fill_asid = '0, inv_asid = '0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [LW-1:0] fill_level = '0;
  logic [BW-1:0] fill_base = '0;
  logic rsp_valid, rsp_hit;
  logic [LW-1:0] rsp_level;
  logic [BW-1:0] rsp_base;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_v [L][E];
  int m_a [L][E];
  int m_t [L][E];
  int m_b [L][E];
  int m_rr [L];

  always #10 clk = ~clk;

  walk_ptr_cache #(.LEVELS(L), .IDX_W(IW), .ENTRIES(E), .ASID_W(AW), .BASE_W(BW)) dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_level(rsp_level), .rsp_base(rsp_base),
    .fill_valid(fill_valid), .fill_level(fill_level), .fill_asid(fill_asid),
    .fill_vpn(fill_vpn), .fill_base(fill_base),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
  );

  function automatic int pmask(int k);
    return ((1 << VW) - 1) & ~((1 << (VW - k * IW)) - 1);
  endfunction

  function automatic void model_look(int a, int v, output int lvl, output int base);
    lvl = 0; base = 0;
    for (int k = 1; k <= L; k++)
      for (int e = 0; e < E; e++)
        if (m_v[k-1][e] != 0 && m_a[k-1][e] == a && m_t[k-1][e] == (v & pmask(k))) begin
          lvl = k; base = m_b[k-1][e];
        end
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; xl < 0 takes the expected answer from the model
  task automatic cyc(bit lk, int la, int lv, bit fl, int flvl, int fa, int fv, int fb,
                     bit ia, bit ie, int iasid, int xl, int xb, string req);
    int el, eb;
    model_look(la, lv, el, eb);
    if (xl >= 0) begin el = xl; eb = xb; end
    lk_valid = lk; lk_asid = AW'(la); lk_vpn = VW'(lv);
    fill_valid = fl; fill_level = LW'(flvl); fill_asid = AW'(fa);
    fill_vpn = VW'(fv); fill_base = BW'(fb);
    inv_all = ia; inv_asid_en = ie; inv_asid = AW'(iasid);
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; inv_all = 0; inv_asid_en = 0;
    if (lk) begin
      check(rsp_valid == 1'b1, "R2", "rsp_valid after request", int'(rsp_valid), 1);
      check(rsp_hit == (el != 0) && int'(rsp_level) == el && int'(rsp_base) == eb, req,
            $sformatf("asid %0d vpn 0x%0h level/base", la, lv),
            (int'(rsp_level) << 8) | int'(rsp_base), (el << 8) | eb);
    end
    if (ia) begin
      for (int k = 0; k < L; k++) for (int e = 0; e < E; e++) m_v[k][e] = 0;
    end else if (ie) begin
      for (int k = 0; k < L; k++) for (int e = 0; e < E; e++)
        if (m_a[k][e] == iasid) m_v[k][e] = 0;
    end else if (fl) begin
      m_v[flvl-1][m_rr[flvl-1]] = 1;
      m_a[flvl-1][m_rr[flvl-1]] = fa;
      m_t[flvl-1][m_rr[flvl-1]] = fv & pmask(flvl);
      m_b[flvl-1][m_rr[flvl-1]] = fb;
      m_rr[flvl-1] = (m_rr[flvl-1] + 1) % E;
    end
  endtask

  task automatic look(int a, int v, int xl, int xb, string req);
    cyc(1, a, v, 0, 1, 0, 0, 0, 0, 0, 0, xl, xb, req);
  endtask

  task automatic fill(int lvl, int a, int v, int b);
    cyc(0, 0, 0, 1, lvl, a, v, b, 0, 0, 0, -1, 0, "");
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < (1 << AW); a++)
      for (int v = 0; v < (1 << VW); v++)
        look(a, v, -1, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < L; k++) begin
      m_rr[k] = 0;
      for (int e = 0; e < E; e++) begin
        m_v[k][e] = 0; m_a[k][e] = 0; m_t[k][e] = 0; m_b[k][e] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 0;
    check(rsp_valid == 0 && rsp_hit == 0, "R1", "outputs after reset",
          int'({rsp_valid, rsp_hit}), 0);
    // R1: empty cache misses everywhere
    sweep("R1");

    // asid 1 chain down to level 3, asid 2 only level 1 with same top field
    fill(1, 1, 6'b100111, 8'h11);
    fill(2, 1, 6'b100111, 8'h12);
    fill(3, 1, 6'b100111, 8'h13);
    fill(1, 2, 6'b100111, 8'h21);
    look(1, 6'b100111, 3, 8'h13, "R5");
    look(1, 6'b100100, 2, 8'h12, "R4");
    look(1, 6'b101100, 1, 8'h11, "R4");
    look(2, 6'b100111, 1, 8'h21, "R3");
    look(0, 6'b100111, 0, 0, "R3");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, -1, 0, "");
    check(rsp_valid == 0, "R2", "no response without request", int'(rsp_valid), 0);
    sweep("R3/R4/R5");

    // third level-1 fill wraps the pointer and evicts the oldest slot
    fill(1, 3, 6'b010000, 8'h31);
    look(1, 6'b100000, 0, 0, "R6");
    look(1, 6'b100100, 2, 8'h12, "R6");
    look(2, 6'b100011, 1, 8'h21, "R6");

    // lookup and fill in one cycle: the lookup sees the old contents
    cyc(1, 3, 6'b110000, 1, 1, 3, 6'b110000, 8'h32, 0, 0, 0, 0, 0, "R2");
    look(3, 6'b110101, 1, 8'h32, "R4");
    look(2, 6'b100111, 0, 0, "R6");

    // fill during an invalidate is dropped
    cyc(0, 0, 0, 1, 2, 3, 6'b011000, 8'h44, 0, 1, 0, -1, 0, "");
    look(3, 6'b011011, 1, 8'h31, "R9");
    cyc(0, 0, 0, 1, 3, 3, 6'b011011, 8'h45, 1, 0, 0, -1, 0, "");
    look(3, 6'b011011, 0, 0, "R9");
    fill(1, 3, 6'b010000, 8'h31);
    fill(1, 3, 6'b110000, 8'h32);
    fill(2, 1, 6'b100111, 8'h12);
    fill(3, 1, 6'b100111, 8'h13);

    // per-identifier invalidate
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1, -1, 0, "");
    look(1, 6'b100111, 0, 0, "R7");
    look(3, 6'b110000, 1, 8'h32, "R7");
    look(3, 6'b010110, 1, 8'h31, "R7");
    sweep("R7");

    // global invalidate
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, -1, 0, "");
    look(3, 6'b110000, 0, 0, "R8");
    sweep("R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule